// File: doc/BRIEF.md
# Single-Wire Bus Master Controller

This block is the master of a single-wire bus with an open-drain data line. It never drives the line high. It only asserts a drive-low enable, and an external pull-up returns the line to the high level. A host issues one command at a time and waits for it to finish. A command is a bus reset with a presence check, a write time slot carrying a one or a zero, or a read time slot that returns one bit.

All bus timing is counted in ticks of a one-microsecond clock enable. A mode input picks either the regular or the overdrive timing set, and the mode is captured when a command is accepted. Every operation starts its first low edge on a tick, so each low phase and each total duration is an exact number of ticks. The returned line level is sampled through a two-flop synchronizer.

Top module: `owire_master`

## Requirements
- R1: After reset, `busy`, `line_drive_low`, `rd_bit` and `presence` are all 0.
- R2: `cmd_code` is decoded as follows: 2'b00 is a bus reset, 2'b01 is a write slot with its bit taken from `cmd_wbit`, and 2'b10 is a read slot. Code 2'b11 is ignored: `busy` and `line_drive_low` stay low and both result flags keep their values.
- R3: A command is accepted only when `cmd_valid` is high while `busy` is low. `busy` is high from the cycle after acceptance until the operation ends. A strobe that arrives while busy has no effect.
- R4: `line_drive_low` rises on the first tick after acceptance. For a bus reset it stays high for exactly 500 ticks in regular mode (`fast_mode`=0) or 64 ticks in overdrive mode (`fast_mode`=1).
- R5: After the reset low phase, the line is released for 480 ticks (regular) or 48 ticks (overdrive) before `busy` falls. Counting the start tick, `busy` therefore spans 981 or 113 ticks.
- R6: `presence` is updated on the 70th tick (regular) or the 9th tick (overdrive) after reset release. It is set to 1 if the line reads low there and cleared otherwise. A low response outside that sample point is not detected. Only a bus reset changes `presence`.
- R7: A write slot drives low for 6 ticks (bit 1) or 60 ticks (bit 0) in regular mode, and for 1 or 7 ticks in overdrive mode. The slot lasts 70 ticks (regular) or 10 ticks (overdrive), so `busy` spans 71 or 11 ticks.
- R8: A read slot drives low for 2 ticks (regular) or 1 tick (overdrive). On the 12th tick (regular) or the 2nd tick (overdrive) after the low edge, it loads `rd_bit` with the line level. The slot length matches R7. Only a read slot changes `rd_bit`.
- R9: The mode is captured at acceptance. Changing `fast_mode` while busy does not alter the running operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_us | input | 1 | One-cycle enable, once per microsecond |
| fast_mode | input | 1 | 0 selects regular timing, 1 selects overdrive timing |
| cmd_valid | input | 1 | Command strobe |
| cmd_code | input | 2 | 00 reset, 01 write, 10 read, 11 none |
| cmd_wbit | input | 1 | Bit value for a write slot |
| busy | output | 1 | Operation in progress |
| rd_bit | output | 1 | Level sampled in the last read slot |
| presence | output | 1 | Presence result of the last bus reset |
| line_in | input | 1 | Level of the bus line (asynchronous) |
| line_drive_low | output | 1 | Enable of the open-drain pull-down |

## Verification
The hardest case to reach from the ports is a slave response that sits near the single presence or read sample point. The bench has to place the low response on precise tick boundaries relative to the master's own edges. It therefore models the slave from tick counts measured since the master's last release or last low edge. Its windows either cover the sample point, end just before it, or start after it, in both speed modes. The bench also measures every low pulse and every busy interval in ticks at the ports. This exposes any off-by-one in the shared phase counter.

// File: rtl/owire_pkg.sv
package owire_pkg;

  localparam int unsigned TM_W = 16;

  typedef enum logic [1:0] {
    CMD_RESET = 2'b00,
    CMD_WRITE = 2'b01,
    CMD_READ  = 2'b10,
    CMD_NONE  = 2'b11
  } cmd_e;

  typedef enum logic [1:0] {
    K_RST = 2'd0,
    K_W1  = 2'd1,
    K_W0  = 2'd2,
    K_RD  = 2'd3
  } kind_e;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_START    = 3'd1,
    ST_RST_LOW  = 3'd2,
    ST_RST_HIGH = 3'd3,
    ST_SLOT     = 3'd4
  } state_e;

  // One speed profile, every field in microsecond ticks
  typedef struct packed {
    logic [TM_W-1:0] rst_low;
    logic [TM_W-1:0] rst_high;
    logic [TM_W-1:0] pres_at;
    logic [TM_W-1:0] slot;
    logic [TM_W-1:0] low_one;
    logic [TM_W-1:0] low_zero;
    logic [TM_W-1:0] low_rd;
    logic [TM_W-1:0] samp_rd;
  } tm_t;

  localparam tm_t TM_STD_DEF = '{
    rst_low: 16'd500, rst_high: 16'd480, pres_at: 16'd70, slot: 16'd70,
    low_one: 16'd6, low_zero: 16'd60, low_rd: 16'd2, samp_rd: 16'd12};

  localparam tm_t TM_FAST_DEF = '{
    rst_low: 16'd64, rst_high: 16'd48, pres_at: 16'd9, slot: 16'd10,
    low_one: 16'd1, low_zero: 16'd7, low_rd: 16'd1, samp_rd: 16'd2};

  function automatic int unsigned tm_max(tm_t a, tm_t b);
    int unsigned m;
    m = 1;
    if (int'(a.rst_low)  > m) m = a.rst_low;
    if (int'(a.rst_high) > m) m = a.rst_high;
    if (int'(a.slot)     > m) m = a.slot;
    if (int'(b.rst_low)  > m) m = b.rst_low;
    if (int'(b.rst_high) > m) m = b.rst_high;
    if (int'(b.slot)     > m) m = b.slot;
    return m;
  endfunction

endpackage

// File: rtl/owire_sync.sv
module owire_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] ff;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) ff[g] <= RST_VAL;
          else        ff[g] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) ff[g] <= RST_VAL;
          else        ff[g] <= ff[g-1];
        end
      end
    end
  endgenerate

  assign q = ff[STAGES-1];

endmodule

// File: rtl/owire_timing.sv
module owire_timing
  import owire_pkg::*;
#(
  parameter tm_t TM_STD  = TM_STD_DEF,
  parameter tm_t TM_FAST = TM_FAST_DEF,
  parameter int  CNT_W   = 9
) (
  input  logic             fast,
  input  kind_e            kind,
  output logic [CNT_W-1:0] rst_low_last,
  output logic [CNT_W-1:0] rst_high_last,
  output logic [CNT_W-1:0] pres_last,
  output logic [CNT_W-1:0] slot_last,
  output logic [CNT_W-1:0] low_last,
  output logic [CNT_W-1:0] samp_last
);

  tm_t             sel;
  logic [TM_W-1:0] low_len;

  always_comb begin
    sel = fast ? TM_FAST : TM_STD;
    unique case (kind)
      K_W1:    low_len = sel.low_one;
      K_W0:    low_len = sel.low_zero;
      default: low_len = sel.low_rd;
    endcase
  end

  // Counters run 0..len-1, so each phase compares against len-1
  assign rst_low_last  = CNT_W'(sel.rst_low  - 16'd1);
  assign rst_high_last = CNT_W'(sel.rst_high - 16'd1);
  assign pres_last     = CNT_W'(sel.pres_at  - 16'd1);
  assign slot_last     = CNT_W'(sel.slot     - 16'd1);
  assign low_last      = CNT_W'(low_len      - 16'd1);
  assign samp_last     = CNT_W'(sel.samp_rd  - 16'd1);

endmodule

// File: rtl/owire_seq.sv
module owire_seq
  import owire_pkg::*;
#(
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_us,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd_code,
  input  logic             cmd_wbit,
  input  logic             fast_mode,
  input  logic             line_s,
  input  logic [CNT_W-1:0] rst_low_last,
  input  logic [CNT_W-1:0] rst_high_last,
  input  logic [CNT_W-1:0] pres_last,
  input  logic [CNT_W-1:0] slot_last,
  input  logic [CNT_W-1:0] low_last,
  input  logic [CNT_W-1:0] samp_last,
  output logic             fast_o,
  output kind_e            kind_o,
  output logic             busy,
  output logic             drive_low,
  output logic             rd_bit,
  output logic             presence
);

  state_e           state_q, state_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             drive_q, drive_n;
  logic             fast_q, fast_n;
  kind_e            kind_q, kind_n;
  logic             rd_q, rd_n;
  logic             pres_q, pres_n;
  cmd_e             code;

  assign code = cmd_e'(cmd_code);

  always_comb begin
    state_n = state_q;
    cnt_n   = cnt_q;
    drive_n = drive_q;
    fast_n  = fast_q;
    kind_n  = kind_q;
    rd_n    = rd_q;
    pres_n  = pres_q;
    unique case (state_q)
      ST_IDLE: begin
        if (cmd_valid && (code != CMD_NONE)) begin
          state_n = ST_START;
          fast_n  = fast_mode;
          if (code == CMD_RESET)      kind_n = K_RST;
          else if (code == CMD_READ)  kind_n = K_RD;
          else if (cmd_wbit)          kind_n = K_W1;
          else                        kind_n = K_W0;
        end
      end
      ST_START: begin
        if (tick_us) begin
          drive_n = 1'b1;
          cnt_n   = '0;
          state_n = (kind_q == K_RST) ? ST_RST_LOW : ST_SLOT;
        end
      end
      ST_RST_LOW: begin
        if (tick_us) begin
          if (cnt_q == rst_low_last) begin
            drive_n = 1'b0;
            cnt_n   = '0;
            state_n = ST_RST_HIGH;
          end else begin
            cnt_n = cnt_q + CNT_W'(1);
          end
        end
      end
      ST_RST_HIGH: begin
        if (tick_us) begin
          if (cnt_q == pres_last) pres_n = ~line_s;
          if (cnt_q == rst_high_last) state_n = ST_IDLE;
          else                        cnt_n   = cnt_q + CNT_W'(1);
        end
      end
      ST_SLOT: begin
        if (tick_us) begin
          if (cnt_q == low_last) drive_n = 1'b0;
          if ((kind_q == K_RD) && (cnt_q == samp_last)) rd_n = line_s;
          if (cnt_q == slot_last) begin
            state_n = ST_IDLE;
            drive_n = 1'b0;
          end else begin
            cnt_n = cnt_q + CNT_W'(1);
          end
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      drive_q <= 1'b0;
      fast_q  <= 1'b0;
      kind_q  <= K_RST;
      rd_q    <= 1'b0;
      pres_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      cnt_q   <= cnt_n;
      drive_q <= drive_n;
      fast_q  <= fast_n;
      kind_q  <= kind_n;
      rd_q    <= rd_n;
      pres_q  <= pres_n;
    end
  end

  assign busy      = (state_q != ST_IDLE);
  assign drive_low = drive_q;
  assign rd_bit    = rd_q;
  assign presence  = pres_q;
  assign fast_o    = fast_q;
  assign kind_o    = kind_q;

  // R4: the pull-down is only active inside an operation
  p_drive_in_op_r4: assert property (@(posedge clk) disable iff (!rst_n)
    drive_q |-> (state_q != ST_IDLE));

  // R4: the first low edge is aligned to a tick after the start state
  p_edge_on_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drive_q) |-> ($past(tick_us) && ($past(state_q) == ST_START)));

  // R2: the unused code leaves the sequencer idle
  p_none_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_IDLE) && cmd_valid && (code == CMD_NONE)) |=> (state_q == ST_IDLE));

  // R9: captured mode holds for the whole operation
  p_mode_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q != ST_IDLE) && ($past(state_q) != ST_IDLE)) |-> $stable(fast_q));

  // R6: presence only moves on a tick in the release phase of a reset
  p_pres_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pres_q) |-> (($past(state_q) == ST_RST_HIGH) && $past(tick_us)));

  // R8: read bit only moves inside a read slot
  p_rd_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rd_q) |-> (($past(state_q) == ST_SLOT) && ($past(kind_q) == K_RD)));

  // R7: once past the low phase of a slot the line stays released
  p_slot_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_SLOT) && (cnt_q > low_last)) |-> !drive_q);

endmodule

// File: rtl/owire_master.sv
module owire_master
  import owire_pkg::*;
#(
  parameter tm_t TM_STD      = TM_STD_DEF,
  parameter tm_t TM_FAST     = TM_FAST_DEF,
  parameter int  SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_us,
  input  logic       fast_mode,
  input  logic       cmd_valid,
  input  logic [1:0] cmd_code,
  input  logic       cmd_wbit,
  output logic       busy,
  output logic       rd_bit,
  output logic       presence,
  input  logic       line_in,
  output logic       line_drive_low
);

  localparam int CNT_W = $clog2(tm_max(TM_STD, TM_FAST));

  logic             rst_n_s;
  logic             line_s;
  logic             fast_q;
  kind_e            kind_q;
  logic [CNT_W-1:0] rst_low_last, rst_high_last, pres_last;
  logic [CNT_W-1:0] slot_last, low_last, samp_last;

  owire_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_rst_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (1'b1),
    .q     (rst_n_s)
  );

  owire_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_line_sync (
    .clk   (clk),
    .rst_n (rst_n_s),
    .d     (line_in),
    .q     (line_s)
  );

  owire_timing #(.TM_STD(TM_STD), .TM_FAST(TM_FAST), .CNT_W(CNT_W)) u_timing (
    .fast          (fast_q),
    .kind          (kind_q),
    .rst_low_last  (rst_low_last),
    .rst_high_last (rst_high_last),
    .pres_last     (pres_last),
    .slot_last     (slot_last),
    .low_last      (low_last),
    .samp_last     (samp_last)
  );

  owire_seq #(.CNT_W(CNT_W)) u_seq (
    .clk           (clk),
    .rst_n         (rst_n_s),
    .tick_us       (tick_us),
    .cmd_valid     (cmd_valid),
    .cmd_code      (cmd_code),
    .cmd_wbit      (cmd_wbit),
    .fast_mode     (fast_mode),
    .line_s        (line_s),
    .rst_low_last  (rst_low_last),
    .rst_high_last (rst_high_last),
    .pres_last     (pres_last),
    .slot_last     (slot_last),
    .low_last      (low_last),
    .samp_last     (samp_last),
    .fast_o        (fast_q),
    .kind_o        (kind_q),
    .busy          (busy),
    .drive_low     (line_drive_low),
    .rd_bit        (rd_bit),
    .presence      (presence)
  );

endmodule

// File: tb/owire_master_tb.sv
`timescale 1ns/1ps
module owire_master_tb;

  logic       clk;
  logic       rst_n;
  logic       tick_us;
  logic       fast_mode;
  logic       cmd_valid;
  logic [1:0] cmd_code;
  logic       cmd_wbit;
  logic       busy, rd_bit, presence, line_in, line_drive_low;

  int nchk;
  int nfail;
  bit done;

  owire_master u_dut (
    .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .fast_mode(fast_mode),
    .cmd_valid(cmd_valid), .cmd_code(cmd_code), .cmd_wbit(cmd_wbit),
    .busy(busy), .rd_bit(rd_bit), .presence(presence),
    .line_in(line_in), .line_drive_low(line_drive_low)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // one tick every four clocks
  logic [1:0] div;
  always @(posedge clk) begin
    if (!rst_n) begin
      div     <= 2'd0;
      tick_us <= 1'b0;
    end else begin
      div     <= div + 2'd1;
      tick_us <= (div == 2'd3);
    end
  end

  // slave model: smode 1 = low while rel in [sa,sb); smode 2 = low while fall < sa
  logic [1:0] smode;
  logic [9:0] sa, sb;
  logic [9:0] rel_cnt, fall_cnt;
  logic       drv_prev;
  logic       slave_low;

  always @(posedge clk) begin
    drv_prev <= line_drive_low;
    if (line_drive_low && !drv_prev)     fall_cnt <= 10'd0;
    else if (tick_us && fall_cnt != 10'h3ff) fall_cnt <= fall_cnt + 10'd1;
    if (!line_drive_low && drv_prev)     rel_cnt <= 10'd0;
    else if (tick_us && rel_cnt != 10'h3ff)  rel_cnt <= rel_cnt + 10'd1;
  end

  always_comb begin
    slave_low = ((smode == 2'd1) && (rel_cnt >= sa) && (rel_cnt < sb)) ||
                ((smode == 2'd2) && (fall_cnt < sa));
    line_in = !(line_drive_low || slave_low);
  end

  // port monitors: ticks of each low pulse and of each busy interval
  int low_run, last_low, busy_run, last_busy;
  always @(posedge clk) begin
    if (line_drive_low) begin
      if (tick_us) low_run <= low_run + 1;
    end else if (low_run != 0) begin
      last_low <= low_run;
      low_run  <= 0;
    end
    if (busy) begin
      if (tick_us) busy_run <= busy_run + 1;
    end else if (busy_run != 0) begin
      last_busy <= busy_run;
      busy_run  <= 0;
    end
  end

  typedef struct packed {
    logic        fast;
    logic [1:0]  code;
    logic        wbit;
    logic [1:0]  smode;
    logic [9:0]  sa;
    logic [9:0]  sb;
    logic [9:0]  exp_low;
    logic [10:0] exp_busy;
    logic        chk_bit;
    logic        exp_bit;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 2'b00, 1'b0, 2'd1, 10'd20, 10'd100, 10'd500, 11'd981, 1'b1, 1'b1},
    '{1'b0, 2'b00, 1'b0, 2'd0, 10'd0,  10'd0,   10'd500, 11'd981, 1'b1, 1'b0},
    '{1'b0, 2'b00, 1'b0, 2'd1, 10'd80, 10'd200, 10'd500, 11'd981, 1'b1, 1'b0},
    '{1'b0, 2'b00, 1'b0, 2'd1, 10'd20, 10'd60,  10'd500, 11'd981, 1'b1, 1'b0},
    '{1'b1, 2'b00, 1'b0, 2'd1, 10'd3,  10'd15,  10'd64,  11'd113, 1'b1, 1'b1},
    '{1'b1, 2'b00, 1'b0, 2'd1, 10'd10, 10'd20,  10'd64,  11'd113, 1'b1, 1'b0},
    '{1'b0, 2'b01, 1'b1, 2'd0, 10'd0,  10'd0,   10'd6,   11'd71,  1'b0, 1'b0},
    '{1'b0, 2'b01, 1'b0, 2'd0, 10'd0,  10'd0,   10'd60,  11'd71,  1'b0, 1'b0},
    '{1'b1, 2'b01, 1'b1, 2'd0, 10'd0,  10'd0,   10'd1,   11'd11,  1'b0, 1'b0},
    '{1'b1, 2'b01, 1'b0, 2'd0, 10'd0,  10'd0,   10'd7,   11'd11,  1'b0, 1'b0},
    '{1'b0, 2'b10, 1'b0, 2'd0, 10'd0,  10'd0,   10'd2,   11'd71,  1'b1, 1'b1},
    '{1'b0, 2'b10, 1'b0, 2'd2, 10'd30, 10'd0,   10'd2,   11'd71,  1'b1, 1'b0},
    '{1'b0, 2'b10, 1'b0, 2'd2, 10'd5,  10'd0,   10'd2,   11'd71,  1'b1, 1'b1},
    '{1'b1, 2'b10, 1'b0, 2'd2, 10'd4,  10'd0,   10'd1,   11'd11,  1'b1, 1'b0},
    '{1'b1, 2'b10, 1'b0, 2'd0, 10'd0,  10'd0,   10'd1,   11'd11,  1'b1, 1'b1}
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic issue(input logic f, input logic [1:0] c, input logic w);
    @(negedge clk);
    fast_mode = f;
    cmd_code  = c;
    cmd_wbit  = w;
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_idle();
    int n;
    n = 0;
    while (busy && n < 20000) begin
      @(negedge clk);
      n++;
    end
    if (busy) check(1'b0, "R3 busy timeout", 1, 0);
    repeat (3) @(negedge clk);
  endtask

  task automatic set_slave(input logic [1:0] m, input logic [9:0] a, input logic [9:0] b);
    smode = m;
    sa    = a;
    sb    = b;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      summary();
      $finish;
    end
  end

  initial begin
    nchk = 0; nfail = 0; done = 1'b0;
    rst_n = 1'b0; fast_mode = 1'b0; cmd_valid = 1'b0; cmd_code = 2'b11; cmd_wbit = 1'b0;
    set_slave(2'd0, 10'd0, 10'd0);
    rel_cnt = 10'h3ff; fall_cnt = 10'h3ff; drv_prev = 1'b0;
    low_run = 0; last_low = 0; busy_run = 0; last_busy = 0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);

    // R1 reset state
    check(busy == 1'b0, "R1 busy", busy, 0);
    check(line_drive_low == 1'b0, "R1 drive", line_drive_low, 0);
    check(presence == 1'b0, "R1 presence", presence, 0);
    check(rd_bit == 1'b0, "R1 rd_bit", rd_bit, 0);

    // vector table
    for (int i = 0; i < NV; i++) begin
      set_slave(VECS[i].smode, VECS[i].sa, VECS[i].sb);
      issue(VECS[i].fast, VECS[i].code, VECS[i].wbit);
      check(busy == 1'b1, "R3 busy after accept", busy, 1);
      wait_idle();
      if (VECS[i].code == 2'b00) begin
        check(last_low == int'(VECS[i].exp_low), "R4 reset low ticks", last_low, int'(VECS[i].exp_low));
        check(last_busy == int'(VECS[i].exp_busy), "R5 reset busy ticks", last_busy, int'(VECS[i].exp_busy));
        check(presence == VECS[i].exp_bit, "R6 presence", presence, VECS[i].exp_bit);
      end else if (VECS[i].code == 2'b01) begin
        check(last_low == int'(VECS[i].exp_low), "R7 write low ticks", last_low, int'(VECS[i].exp_low));
        check(last_busy == int'(VECS[i].exp_busy), "R7 write slot ticks", last_busy, int'(VECS[i].exp_busy));
      end else begin
        check(last_low == int'(VECS[i].exp_low), "R8 read low ticks", last_low, int'(VECS[i].exp_low));
        check(last_busy == int'(VECS[i].exp_busy), "R8 read slot ticks", last_busy, int'(VECS[i].exp_busy));
        if (VECS[i].chk_bit)
          check(rd_bit == VECS[i].exp_bit, "R8 read bit", rd_bit, VECS[i].exp_bit);
      end
      set_slave(2'd0, 10'd0, 10'd0);
    end

    // R2: unused code has no effect
    begin
      int act;
      logic pres0, rd0;
      act = 0; pres0 = presence; rd0 = rd_bit;
      issue(1'b0, 2'b11, 1'b0);
      for (int k = 0; k < 40; k++) begin
        @(negedge clk);
        if (busy || line_drive_low) act++;
      end
      check(act == 0, "R2 ignored code activity", act, 0);
      check(presence == pres0 && rd_bit == rd0, "R2 flags kept", {presence, rd_bit}, {pres0, rd0});
    end

    // R3: strobe while busy is ignored
    issue(1'b0, 2'b01, 1'b0);
    repeat (20) @(negedge clk);
    cmd_code = 2'b00; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    wait_idle();
    check(last_low == 60, "R3 low unchanged by busy strobe", last_low, 60);
    check(last_busy == 71, "R3 slot unchanged by busy strobe", last_busy, 71);
    begin
      int act;
      act = 0;
      for (int k = 0; k < 40; k++) begin
        @(negedge clk);
        if (busy) act++;
      end
      check(act == 0, "R3 no queued command", act, 0);
    end

    // R9: mode captured at acceptance
    issue(1'b1, 2'b01, 1'b0);
    fast_mode = 1'b0;
    wait_idle();
    check(last_low == 7, "R9 low uses captured mode", last_low, 7);
    check(last_busy == 11, "R9 slot uses captured mode", last_busy, 11);

    // R6: presence only changed by reset; R8: rd_bit only changed by read
    set_slave(2'd1, 10'd3, 10'd15);
    issue(1'b1, 2'b00, 1'b0);
    wait_idle();
    check(presence == 1'b1, "R6 presence set", presence, 1);
    set_slave(2'd2, 10'd4, 10'd0);
    issue(1'b1, 2'b10, 1'b0);
    wait_idle();
    check(rd_bit == 1'b0, "R8 read zero", rd_bit, 0);
    check(presence == 1'b1, "R6 presence kept over read", presence, 1);
    set_slave(2'd0, 10'd0, 10'd0);
    issue(1'b0, 2'b01, 1'b1);
    wait_idle();
    check(rd_bit == 1'b0, "R8 rd_bit kept over write", rd_bit, 0);
    check(presence == 1'b1, "R6 presence kept over write", presence, 1);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule